// File: doc/BRIEF.md
# UART Baud Rate Down-Counter

This block produces the timing enables a UART needs from a single programmable divider. A 12-bit reload value is held in two parts. One part is a low byte and the other is a high nibble, and each part has its own write strobe. A down-counter running on the system clock counts from the reload value to zero. Each time it reaches zero it raises a one-cycle tick and loads the reload value again. That raw tick is the receiver's oversampling enable: the receiver's recovery logic counts 16, 8 or 2 ticks per bit, depending on mode.

A second divider stage counts ticks and raises the transmitter bit enable once per bit period. It counts 16 ticks in normal asynchronous mode, 8 in double-speed asynchronous mode and 2 in synchronous master mode. In synchronous master mode the block also drives a serial clock output that toggles on every tick. The bit rates that result are fclk/(16·(U+1)), fclk/(8·(U+1)) and fclk/(2·(U+1)), where U is the reload value. Writing the low byte restarts the whole chain at once, so software gets a known phase after any rate change.

Top module: `baud_gen`

## Requirements
- R1: While rstN is low, rxSampleEn, txBitEn and xckOut are 0. Reset leaves the reload value and the counter at 0.
- R2: With reload value U = {high nibble, low byte}, rxSampleEn pulses for one cycle every U+1 clock cycles.
- R3: A low-byte write at clock edge E loads the counter at once. rxSampleEn is 0 in the cycle after E, and the first tick follows U+1 edges after E.
- R4: A high-nibble write changes the stored reload value but does not disturb the count in progress. The new value takes effect at the next zero of the counter.
- R5: With U = 0 (including the value after reset), rxSampleEn is high on every cycle.
- R6: In normal asynchronous mode (syncMode=0, dblSpeed=0), txBitEn is high on every 16th tick. The count starts from the last low-byte write.
- R7: In double-speed asynchronous mode (syncMode=0, dblSpeed=1), txBitEn is high on every 8th tick.
- R8: In synchronous master mode (syncMode=1), txBitEn is high on every 2nd tick, and dblSpeed has no effect.
- R9: In synchronous master mode, xckOut is 0 after a low-byte write and toggles in the cycle after each tick, so its period is two ticks. In asynchronous mode xckOut stays 0.
- R10: txBitEn is never high in a cycle where rxSampleEn is low.
- R11: The full reload value 4095 gives a tick period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lowWr | input | 1 | Write strobe for the low reload byte; also reloads the counter |
| highWr | input | 1 | Write strobe for the high reload nibble |
| wrData | input | 8 | Write data; only the lower 4 bits are used by a high-nibble write |
| syncMode | input | 1 | 1 selects synchronous master mode |
| dblSpeed | input | 1 | 1 selects double speed in asynchronous mode |
| rxSampleEn | output | 1 | Raw tick, used as the receiver oversampling enable |
| txBitEn | output | 1 | Transmitter bit enable |
| xckOut | output | 1 | Synchronous master clock output |

## Verification
The assertions assume that the mode inputs change only together with, or just before, a low-byte write. Under that assumption the divider phase and the serial clock phase stay defined. The assertions also assume that lowWr is a single-cycle strobe from a host that does not hold it. The stimulus sets syncMode and dblSpeed first, then writes the high nibble, then writes the low byte, so every expected sequence starts from a known reload point. The only write made in mid-count is a high-nibble write, placed well before the counter reaches zero.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int PRE_W = 4;

  typedef enum logic [1:0] {
    MODE_ASYNC      = 2'd0,
    MODE_ASYNC_FAST = 2'd1,
    MODE_SYNC       = 2'd2
  } rate_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             syncOn;
    logic [PRE_W-1:0] divLast;
  } ctrl_strobe_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int RELOAD_W = 12,
  parameter int LOW_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lowWr,
  input  logic                highWr,
  input  logic [LOW_W-1:0]    wrData,
  input  logic                syncMode,
  input  logic                dblSpeed,
  output ctrl_strobe_t        strb,
  output logic [RELOAD_W-1:0] reloadVal
);
  localparam int HIGH_W = RELOAD_W - LOW_W;

  logic [LOW_W-1:0]  loReg;
  logic [HIGH_W-1:0] hiReg;
  logic [HIGH_W-1:0] hiNext;
  rate_mode_e        rateMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg <= '0;
      hiReg <= '0;
    end else begin
      if (lowWr)  loReg <= wrData;
      if (highWr) hiReg <= wrData[HIGH_W-1:0];
    end
  end

  assign hiNext    = highWr ? wrData[HIGH_W-1:0] : hiReg;
  assign reloadVal = lowWr ? {hiNext, wrData} : {hiReg, loReg};

  always_comb begin
    if (syncMode)      rateMode = MODE_SYNC;
    else if (dblSpeed) rateMode = MODE_ASYNC_FAST;
    else               rateMode = MODE_ASYNC;
  end

  always_comb begin
    strb.load   = lowWr;
    strb.syncOn = (rateMode == MODE_SYNC);
    case (rateMode)
      MODE_ASYNC_FAST: strb.divLast = PRE_W'(7);
      MODE_SYNC:       strb.divLast = PRE_W'(1);
      default:         strb.divLast = PRE_W'(15);
    endcase
  end
endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strb,
  input  logic [RELOAD_W-1:0] reloadVal,
  output logic                tick,
  output logic                bitEn,
  output logic                xck
);
  logic [RELOAD_W-1:0] cnt;
  logic [PRE_W-1:0]    preCnt;
  logic                tickQ;
  logic                xckQ;
  logic                atZero;

  assign atZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      tickQ  <= 1'b0;
      preCnt <= '0;
    end else if (strb.load) begin
      cnt    <= reloadVal;
      tickQ  <= 1'b0;
      preCnt <= '0;
    end else begin
      tickQ <= atZero;
      cnt   <= atZero ? reloadVal : cnt - RELOAD_W'(1);
      if (tickQ)
        preCnt <= (preCnt >= strb.divLast) ? '0 : preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strb.syncOn || strb.load) xckQ <= 1'b0;
    else if (tickQ)                          xckQ <= ~xckQ;
  end

  assign tick  = tickQ;
  assign bitEn = tickQ && (preCnt >= strb.divLast);
  assign xck   = xckQ;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int RELOAD_W = 12,
  parameter int LOW_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lowWr,
  input  logic             highWr,
  input  logic [LOW_W-1:0] wrData,
  input  logic             syncMode,
  input  logic             dblSpeed,
  output logic             rxSampleEn,
  output logic             txBitEn,
  output logic             xckOut
);
  ctrl_strobe_t        strb;
  logic [RELOAD_W-1:0] reloadVal;

  baud_ctrl #(.RELOAD_W(RELOAD_W), .LOW_W(LOW_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .lowWr(lowWr), .highWr(highWr), .wrData(wrData),
    .syncMode(syncMode), .dblSpeed(dblSpeed), .strb(strb), .reloadVal(reloadVal)
  );

  baud_dp #(.RELOAD_W(RELOAD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .tick(rxSampleEn), .bitEn(txBitEn), .xck(xckOut)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk,
  input logic rstN,
  input logic lowWr,
  input logic syncMode,
  input logic rxSampleEn,
  input logic txBitEn,
  input logic xckOut
);
  // R10
  txen_with_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBitEn |-> rxSampleEn);

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowWr |=> !rxSampleEn);

  // R9
  xck_async_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncMode |=> !xckOut);

  // R9
  xck_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && rxSampleEn && !lowWr) |=> (xckOut != $past(xckOut)));
endmodule

bind baud_gen baud_gen_chk i_chk (
  .clk(clk), .rstN(rstN), .lowWr(lowWr), .syncMode(syncMode),
  .rxSampleEn(rxSampleEn), .txBitEn(txBitEn), .xckOut(xckOut)
);

// File: tb/test_baud_gen.sv
module test_baud_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowWr = 1'b0;
  logic highWr = 1'b0;
  logic [7:0] wrData = '0;
  logic syncMode = 1'b0;
  logic dblSpeed = 1'b0;
  logic rxSampleEn, txBitEn, xckOut;

  int nTests = 0;
  int nFail = 0;
  int unsigned cyc = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int unsigned at;
    bit          tx;
    bit          xck;
    string       req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  baud_gen i_baud_gen (
    .clk(clk), .rstN(rstN), .lowWr(lowWr), .highWr(highWr), .wrData(wrData),
    .syncMode(syncMode), .dblSpeed(dblSpeed),
    .rxSampleEn(rxSampleEn), .txBitEn(txBitEn), .xckOut(xckOut)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops expected ticks as they appear
  always @(negedge clk) begin
    if (rstN && txBitEn && !rxSampleEn)
      chk(1'b0, "R10", "txBitEn without tick", 1, 0);
    if (armed) begin
      if (rxSampleEn) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "unexpected tick", 1, 0);
          armed = 1'b0;
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.at, e.req, "tick cycle", int'(cyc), int'(e.at));
          chk(txBitEn == e.tx, e.req, "txBitEn", int'(txBitEn), int'(e.tx));
          chk(xckOut == e.xck, "R9", "xckOut", int'(xckOut), int'(e.xck));
          if (q.size() == 0) armed = 1'b0;
        end
      end else if (q.size() > 0 && cyc >= q[0].at) begin
        chk(1'b0, q[0].req, "missing tick", 0, 1);
        q.delete();
        armed = 1'b0;
      end
    end
  end

  // Driver: program a rate and push the expected tick sequence
  task automatic runRate(int hi, int lo, bit sync, bit dbl, int nTicks,
                         string req, int hi2 = -1);
    int unsigned e0, t;
    int div, u1, u2;
    @(negedge clk);
    armed = 1'b0;
    q.delete();
    syncMode = sync;
    dblSpeed = dbl;
    highWr = 1'b1;
    wrData = 8'(hi);
    @(negedge clk);
    highWr = 1'b0;
    lowWr = 1'b1;
    wrData = 8'(lo);
    e0 = cyc + 1;
    @(negedge clk);
    lowWr = 1'b0;
    div = sync ? 2 : (dbl ? 8 : 16);
    u1 = hi * 256 + lo;
    u2 = (hi2 >= 0) ? hi2 * 256 + lo : u1;
    t = e0 + u1 + 1;
    for (int n = 1; n <= nTicks; n++) begin
      exp_t x;
      x.at = t;
      x.tx = (n % div) == 0;
      x.xck = sync ? bit'((n - 1) % 2) : 1'b0;
      x.req = req;
      q.push_back(x);
      t += u2 + 1;
    end
    armed = 1'b1;
    if (hi2 >= 0) begin
      @(negedge clk);
      highWr = 1'b1;
      wrData = 8'(hi2);
      @(negedge clk);
      highWr = 1'b0;
    end
    while (armed) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!rxSampleEn && !txBitEn && !xckOut, "R1", "outputs in reset",
        int'({rxSampleEn, txBitEn, xckOut}), 0);
    rstN = 1'b1;
    // R5: zero reload after reset ticks every cycle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rxSampleEn, "R5", "tick each cycle after reset", int'(rxSampleEn), 1);
    end
    runRate(0, 5, 1'b0, 1'b0, 40, "R6");      // R2 R3 R6
    runRate(0, 0, 1'b0, 1'b1, 20, "R7");      // R5 R7
    runRate(0, 3, 1'b1, 1'b1, 12, "R8");      // R8 R9, dblSpeed ignored
    runRate(0, 9, 1'b1, 1'b0, 8, "R8");       // R8 R9
    runRate(0, 16, 1'b0, 1'b0, 5, "R4", 1);   // R4 high nibble deferred
    runRate(15, 255, 1'b0, 1'b0, 3, "R11");   // R11 full range
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule